// File: doc/BRIEF.md
# Multi-Level Round-Robin Process Dispatcher

This block picks at most one process slot to run per evaluation pass. Each slot carries a valid bit, a two-bit level field and a three-bit state code. A pulse on `passStart` freezes all the per-slot inputs into a snapshot. These inputs are the timer-expiry vector, the device-signal vector, the valid bits, the levels and the states. The block then looks for an eligible slot. It tries level 0 first, then level 1, then level 2. Inside a level it walks the members in round-robin order, starting from that level's own head pointer.

The result appears as single-cycle strobes. They give the winning slot as an index, a one-hot vector and a level. They also give a result code (OK or Timeout). Three side-effect strobes tell the surrounding logic to clear the device signal, to cancel the pending delay, or to reload the period of each expired timer consumed by the pass. The owner of the slot state stores `Active` for the granted slot when it sees `grantValid`. The timers, the device-signal capture and the execution of processes sit outside this block.

Top module: `process_dispatcher`

## Requirements
- R1: Level 0 is searched first, then level 1, then level 2. An eligible slot at a lower-numbered level always wins over one at a higher-numbered level. A slot with `slotValid` low, or with level code 3, belongs to no level and is never granted.
- R2: Each level keeps its own head pointer. The head of every level is 0 after reset. The search in a level begins at its head slot index and goes upward, wrapping modulo the slot count. After a grant, only the granted level's head moves, to the slot index just after the winner.
- R3: When `passStart` is sampled high in the idle phase, the block captures all per-slot inputs. The whole pass uses only that snapshot, so changes to the inputs after that edge do not affect the result.
- R4: The result strobes appear in the cycle that follows the second rising edge after `passStart` was sampled, and they last one cycle. A pass produces either `grantValid` (with a one-hot `grantOneHot` matching `grantIdx`) or `noGrant`, never both. A `passStart` seen during the evaluation cycle is ignored.
- R5: For a slot, a set device-signal bit is checked before its timer bit. A grant caused by a device signal gives result OK (`resultTimeout`=0) and raises `clrDevSig`. It raises `cancelDelay` only when the slot state is 4 (awaiting device signal with timeout).
- R6: A grant caused by a timer expiry sets the winner's bit in `reloadMask`. If the state is 4, it also raises `clrDevSig` and sets `resultTimeout`=1. Otherwise the result is OK and `clrDevSig` stays low. `cancelDelay` is never raised on a timer grant.
- R7: A slot in state 2 (suspended) or state 3 (awaiting device signal only) is not granted on a timer expiry alone, and the search goes on to the next member. If the search visits such a slot with its timer bit set and no device bit, that slot's bit is set in `reloadMask`. State codes: 0 idle, 1 active, 2 suspended, 3 awaiting device, 4 awaiting device with timeout.
- R8: When no slot is eligible at any level, the pass raises `noGrant` and leaves every head pointer unchanged.
- R9: While reset is held, and after it is released, all output strobes and vectors are zero until a pass completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| passStart | input | 1 | Starts an evaluation pass and captures the snapshot |
| timerReady | input | NUM_SLOTS | Per-slot timer expired |
| devReady | input | NUM_SLOTS | Per-slot device signal pending |
| slotValid | input | NUM_SLOTS | Slot is a ring member |
| slotPrio | input | 2*NUM_SLOTS | Per-slot level code, slot i at bits [2i+1:2i] |
| slotState | input | 3*NUM_SLOTS | Per-slot state code, slot i at bits [3i+2:3i] |
| grantValid | output | 1 | A slot was granted this pass |
| grantIdx | output | IDXW | Index of granted slot |
| grantOneHot | output | NUM_SLOTS | One-hot granted slot |
| grantLevel | output | 2 | Level of granted slot |
| resultTimeout | output | 1 | 1 = Timeout, 0 = OK |
| clrDevSig | output | 1 | Clear device signal of granted slot |
| cancelDelay | output | 1 | Cancel delay timer of granted slot |
| reloadMask | output | NUM_SLOTS | Slots whose timer period is reloaded |
| noGrant | output | 1 | Pass ended with nothing eligible |

## Verification
Some properties are checked on every cycle by the assertions: grant and no-grant exclude each other, a grant is one-hot and matches its index, heads move only with a grant, each evaluation is followed by exactly one outcome, and the strobe combinations are legal (cancel only on a device grant, timeout only with reload). Other behaviours can only be shown by the bench's sweeps against its own model: which slot wins across levels and inside a rotating ring, the exact reload mask of blocked timers visited, snapshot isolation, and the dropping of a `passStart` given during evaluation.

// File: rtl/dispatch_pkg.sv
package dispatch_pkg;
  localparam int LEVELS = 3;
  localparam int PRIOW  = 2;
  localparam int STW    = 3;

  typedef enum logic [STW-1:0] {
    ST_IDLE         = 3'd0,
    ST_ACTIVE       = 3'd1,
    ST_SUSPENDED    = 3'd2,
    ST_AWAIT_DEV    = 3'd3,
    ST_AWAIT_DEV_TO = 3'd4
  } slot_state_e;

  typedef struct packed {
    logic capture;
    logic evaluate;
  } ctrl_strobe_t;
endpackage

// File: rtl/dispatch_ctrl.sv
module dispatch_ctrl
  import dispatch_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         passStart,
  output ctrl_strobe_t strobes
);
  typedef enum logic {PH_IDLE, PH_EVAL} phase_e;
  phase_e phase;

  always_ff @(posedge clk) begin
    if (!rstN) phase <= PH_IDLE;
    else if (phase == PH_IDLE && passStart) phase <= PH_EVAL;
    else phase <= PH_IDLE;
  end

  always_comb begin
    strobes.capture  = (phase == PH_IDLE) && passStart;
    strobes.evaluate = (phase == PH_EVAL);
  end

  // R4: evaluation lasts a single cycle and always follows a capture
  assert_eval_after_capture_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evaluate |-> $past(strobes.capture));
  assert_eval_single_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evaluate |=> !strobes.evaluate);
endmodule

// File: rtl/dispatch_datapath.sv
module dispatch_datapath
  import dispatch_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDXW = $clog2(NUM_SLOTS)
)(
  input  logic                       clk,
  input  logic                       rstN,
  input  ctrl_strobe_t               strobes,
  input  logic [NUM_SLOTS-1:0]       timerReady,
  input  logic [NUM_SLOTS-1:0]       devReady,
  input  logic [NUM_SLOTS-1:0]       slotValid,
  input  logic [PRIOW*NUM_SLOTS-1:0] slotPrio,
  input  logic [STW*NUM_SLOTS-1:0]   slotState,
  output logic                       grantValid,
  output logic [IDXW-1:0]            grantIdx,
  output logic [NUM_SLOTS-1:0]       grantOneHot,
  output logic [1:0]                 grantLevel,
  output logic                       resultTimeout,
  output logic                       clrDevSig,
  output logic                       cancelDelay,
  output logic [NUM_SLOTS-1:0]       reloadMask,
  output logic                       noGrant
);
  // snapshot registers
  logic [NUM_SLOTS-1:0]       snapTimer, snapDev, snapValid;
  logic [PRIOW*NUM_SLOTS-1:0] snapPrio;
  logic [STW*NUM_SLOTS-1:0]   snapState;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      snapTimer <= '0;
      snapDev   <= '0;
      snapValid <= '0;
      snapPrio  <= '0;
      snapState <= '0;
    end else if (strobes.capture) begin
      snapTimer <= timerReady;
      snapDev   <= devReady;
      snapValid <= slotValid;
      snapPrio  <= slotPrio;
      snapState <= slotState;
    end
  end

  // per-slot decode
  logic [NUM_SLOTS-1:0] eligVec, blockedVec, awaitToVec;
  logic [LEVELS-1:0][NUM_SLOTS-1:0] memberVec;

  for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
    slot_state_e st;
    logic        timerBlocked;
    assign st           = slot_state_e'(snapState[i*STW +: STW]);
    assign timerBlocked = (st == ST_SUSPENDED) || (st == ST_AWAIT_DEV);
    assign eligVec[i]    = snapDev[i] | (snapTimer[i] & ~timerBlocked);
    assign blockedVec[i] = snapTimer[i] & ~snapDev[i] & timerBlocked;
    assign awaitToVec[i] = (st == ST_AWAIT_DEV_TO);
    for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
      assign memberVec[l][i] = snapValid[i] && (snapPrio[i*PRIOW +: PRIOW] == PRIOW'(l));
    end
  end

  // per-level round-robin search
  logic [LEVELS-1:0][IDXW-1:0]      head;
  logic [LEVELS-1:0]                found;
  logic [LEVELS-1:0][IDXW-1:0]      pickIdx;
  logic [LEVELS-1:0][NUM_SLOTS-1:0] visitMask;

  always_comb begin
    for (int l = 0; l < LEVELS; l++) begin
      found[l]     = 1'b0;
      pickIdx[l]   = '0;
      visitMask[l] = '0;
      for (int k = 0; k < NUM_SLOTS; k++) begin
        int idx;
        idx = (int'(head[l]) + k) % NUM_SLOTS;
        if (memberVec[l][idx] && !found[l]) begin
          if (eligVec[idx]) begin
            found[l]   = 1'b1;
            pickIdx[l] = IDXW'(idx);
          end else begin
            visitMask[l][idx] = 1'b1;
          end
        end
      end
    end
  end

  // level selection
  logic                 anyFound;
  logic [1:0]           winLevel;
  logic [IDXW-1:0]      winIdx;
  logic [NUM_SLOTS-1:0] winOneHot;
  logic [NUM_SLOTS-1:0] skipReload;
  logic                 winViaDev, winAwaitTo;

  always_comb begin
    anyFound   = 1'b0;
    winLevel   = '0;
    winIdx     = '0;
    skipReload = '0;
    for (int l = 0; l < LEVELS; l++) begin
      if (!anyFound) begin
        skipReload = skipReload | (visitMask[l] & blockedVec);
        if (found[l]) begin
          anyFound = 1'b1;
          winLevel = 2'(l);
          winIdx   = pickIdx[l];
        end
      end
    end
    winOneHot  = anyFound ? (NUM_SLOTS'(1) << winIdx) : '0;
    winViaDev  = anyFound && snapDev[winIdx];
    winAwaitTo = anyFound && awaitToVec[winIdx];
  end

  // result registers and head update
  always_ff @(posedge clk) begin
    if (!rstN) begin
      head          <= '0;
      grantValid    <= 1'b0;
      grantIdx      <= '0;
      grantOneHot   <= '0;
      grantLevel    <= '0;
      resultTimeout <= 1'b0;
      clrDevSig     <= 1'b0;
      cancelDelay   <= 1'b0;
      reloadMask    <= '0;
      noGrant       <= 1'b0;
    end else if (strobes.evaluate) begin
      grantValid    <= anyFound;
      grantIdx      <= winIdx;
      grantOneHot   <= winOneHot;
      grantLevel    <= winLevel;
      resultTimeout <= anyFound && !winViaDev && winAwaitTo;
      clrDevSig     <= anyFound && (winViaDev || winAwaitTo);
      cancelDelay   <= winViaDev && winAwaitTo;
      reloadMask    <= skipReload | ((anyFound && !winViaDev) ? winOneHot : '0);
      noGrant       <= !anyFound;
      if (anyFound) head[winLevel] <= IDXW'((int'(winIdx) + 1) % NUM_SLOTS);
    end else begin
      grantValid    <= 1'b0;
      grantIdx      <= '0;
      grantOneHot   <= '0;
      grantLevel    <= '0;
      resultTimeout <= 1'b0;
      clrDevSig     <= 1'b0;
      cancelDelay   <= 1'b0;
      reloadMask    <= '0;
      noGrant       <= 1'b0;
    end
  end

  // R4: outcome exclusivity and completeness
  assert_outcome_exclusive_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(grantValid && noGrant));
  assert_outcome_follows_eval_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.evaluate |=> (grantValid || noGrant));
  assert_grant_onehot_R4: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> ($countones(grantOneHot) == 1 && grantOneHot[grantIdx]));
  // R1: a granted slot is a valid member of the reported level
  assert_grant_member_R1: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (snapValid[grantIdx] && snapPrio[grantIdx*PRIOW +: PRIOW] == grantLevel));
  // R2 / R8: heads move only together with a grant
  assert_head_still_R8: assert property (@(posedge clk) disable iff (!rstN)
    !grantValid |-> head == $past(head));
  // R5: cancel only on a device grant with OK
  assert_cancel_dev_R5: assert property (@(posedge clk) disable iff (!rstN)
    cancelDelay |-> (grantValid && clrDevSig && !resultTimeout && !reloadMask[grantIdx]));
  // R6: a timeout always comes with a reload of the winner and a clear
  assert_timeout_reload_R6: assert property (@(posedge clk) disable iff (!rstN)
    resultTimeout |-> (grantValid && reloadMask[grantIdx] && clrDevSig));
endmodule

// File: rtl/process_dispatcher.sv
module process_dispatcher
  import dispatch_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  localparam int IDXW = $clog2(NUM_SLOTS)
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   passStart,
  input  logic [NUM_SLOTS-1:0]   timerReady,
  input  logic [NUM_SLOTS-1:0]   devReady,
  input  logic [NUM_SLOTS-1:0]   slotValid,
  input  logic [2*NUM_SLOTS-1:0] slotPrio,
  input  logic [3*NUM_SLOTS-1:0] slotState,
  output logic                   grantValid,
  output logic [IDXW-1:0]        grantIdx,
  output logic [NUM_SLOTS-1:0]   grantOneHot,
  output logic [1:0]             grantLevel,
  output logic                   resultTimeout,
  output logic                   clrDevSig,
  output logic                   cancelDelay,
  output logic [NUM_SLOTS-1:0]   reloadMask,
  output logic                   noGrant
);
  ctrl_strobe_t strobes;

  dispatch_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .passStart (passStart),
    .strobes   (strobes)
  );

  dispatch_datapath #(.NUM_SLOTS(NUM_SLOTS)) i_datapath (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .timerReady    (timerReady),
    .devReady      (devReady),
    .slotValid     (slotValid),
    .slotPrio      (slotPrio),
    .slotState     (slotState),
    .grantValid    (grantValid),
    .grantIdx      (grantIdx),
    .grantOneHot   (grantOneHot),
    .grantLevel    (grantLevel),
    .resultTimeout (resultTimeout),
    .clrDevSig     (clrDevSig),
    .cancelDelay   (cancelDelay),
    .reloadMask    (reloadMask),
    .noGrant       (noGrant)
  );
endmodule

// File: tb/test_process_dispatcher.sv
module test_process_dispatcher;
  localparam int NS = 4;
  localparam int IW = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic passStart = 1'b0;
  logic [NS-1:0] timerReady = '0, devReady = '0, slotValid = '0;
  logic [2*NS-1:0] slotPrio;
  logic [3*NS-1:0] slotState;
  logic grantValid, resultTimeout, clrDevSig, cancelDelay, noGrant;
  logic [IW-1:0] grantIdx;
  logic [NS-1:0] grantOneHot, reloadMask;
  logic [1:0] grantLevel;

  int cPrio [NS];
  int cState [NS];
  int mHead [3];
  int checks = 0, fails = 0;
  bit finished = 0;

  always #2.5ns clk = ~clk;

  always_comb begin
    for (int i = 0; i < NS; i++) begin
      slotPrio[2*i +: 2]  = 2'(cPrio[i]);
      slotState[3*i +: 3] = 3'(cState[i]);
    end
  end

  process_dispatcher #(.NUM_SLOTS(NS)) i_process_dispatcher (
    .clk(clk), .rstN(rstN), .passStart(passStart),
    .timerReady(timerReady), .devReady(devReady), .slotValid(slotValid),
    .slotPrio(slotPrio), .slotState(slotState),
    .grantValid(grantValid), .grantIdx(grantIdx), .grantOneHot(grantOneHot),
    .grantLevel(grantLevel), .resultTimeout(resultTimeout), .clrDevSig(clrDevSig),
    .cancelDelay(cancelDelay), .reloadMask(reloadMask), .noGrant(noGrant)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // expected outcome of one pass, from the requirements
  logic eGrant, eClr, eCancel, eTo;
  int   eIdx, eLvl;
  logic [NS-1:0] eReload;

  task automatic model(input logic [NS-1:0] dv, input logic [NS-1:0] tm);
    eGrant = 0; eClr = 0; eCancel = 0; eTo = 0; eIdx = 0; eLvl = 0; eReload = '0;
    for (int lv = 0; lv < 3; lv++) begin
      for (int k = 0; k < NS; k++) begin
        int s;
        bit blk;
        s = (mHead[lv] + k) % NS;
        blk = (cState[s] == 2) || (cState[s] == 3);
        if (!eGrant && slotValid[s] && cPrio[s] == lv) begin
          if (dv[s] || (tm[s] && !blk)) begin
            eGrant = 1; eIdx = s; eLvl = lv;
            eClr    = dv[s] || cState[s] == 4;
            eCancel = dv[s] && cState[s] == 4;
            eTo     = !dv[s] && cState[s] == 4;
            if (!dv[s]) eReload[s] = 1'b1;
            mHead[lv] = (s + 1) % NS;
          end else if (tm[s]) begin
            eReload[s] = 1'b1;
          end
        end
      end
    end
  endtask

  task automatic compare(input string tag);
    logic [31:0] a, e;
    a = {grantValid, noGrant, 2'(grantLevel), 4'(grantIdx), 4'(grantOneHot)};
    e = {eGrant, !eGrant, eGrant ? 2'(eLvl) : 2'd0, eGrant ? 4'(eIdx) : 4'd0,
         eGrant ? 4'(1 << eIdx) : 4'd0};
    check(a == e, {tag, " grant selection R1 R2 R8"}, a, e);
    a = {resultTimeout, clrDevSig, cancelDelay};
    e = {eTo, eClr, eCancel};
    check(a == e, {tag, " result and strobes R5 R6"}, a, e);
    check(reloadMask == eReload, {tag, " reload mask R6 R7"}, 32'(reloadMask), 32'(eReload));
  endtask

  // one pass: drive at negedge, sample two edges later at negedge
  task automatic runPass(input logic [NS-1:0] dv, input logic [NS-1:0] tm, input string tag);
    devReady = dv; timerReady = tm; passStart = 1'b1;
    @(negedge clk);
    passStart = 1'b0;
    devReady = ~dv; timerReady = ~tm;  // R3: post-capture changes must be ignored
    @(negedge clk);
    model(dv, tm);
    compare(tag);
  endtask

  task automatic setCfg(input logic [NS-1:0] v, input int p0, p1, p2, p3,
                        input int s0, s1, s2, s3);
    slotValid = v;
    cPrio[0] = p0; cPrio[1] = p1; cPrio[2] = p2; cPrio[3] = p3;
    cState[0] = s0; cState[1] = s1; cState[2] = s2; cState[3] = s3;
  endtask

  initial begin
    for (int l = 0; l < 3; l++) mHead[l] = 0;
    setCfg(4'b1111, 0, 1, 0, 2, 0, 4, 2, 3);
    repeat (3) @(negedge clk);
    // R9: reset state
    check({grantValid, noGrant, grantOneHot, reloadMask, clrDevSig, cancelDelay, resultTimeout} == '0,
          "R9 outputs zero in reset", 32'(grantOneHot), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check(!grantValid && !noGrant && reloadMask == '0, "R9 outputs zero after reset",
          32'({grantValid, noGrant}), 32'd0);

    // R3: snapshot isolation; nothing ready at capture, everything ready after
    runPass(4'b0000, 4'b0000, "R3 snapshot");

    // R4: passStart held two cycles gives a single pass
    devReady = 4'b0001; timerReady = '0; passStart = 1'b1;
    @(negedge clk);
    @(negedge clk);
    passStart = 1'b0;
    model(4'b0001, 4'b0000);
    check(grantValid && grantIdx == 0, "R4 first pass granted", 32'(grantIdx), 32'd0);
    @(negedge clk);
    check(!grantValid && !noGrant, "R4 second passStart ignored", 32'({grantValid, noGrant}), 32'd0);

    // R2: rotation inside a level, all slots level 1 and idle with timers
    setCfg(4'b1111, 1, 1, 1, 1, 0, 0, 0, 0);
    for (int r = 0; r < 6; r++) runPass(4'b0000, 4'b1111, "R2 rotation");

    // R1: level-3 and invalid slots never granted
    setCfg(4'b1011, 3, 2, 1, 3, 0, 0, 0, 0);
    runPass(4'b1001, 4'b1101, "R1 excluded slots");

    // exhaustive sweeps over ready patterns on several configurations
    for (int c = 0; c < 3; c++) begin
      if (c == 0) setCfg(4'b1111, 0, 1, 0, 2, 0, 4, 2, 3);
      else if (c == 1) setCfg(4'b1111, 1, 1, 1, 1, 3, 0, 4, 2);
      else setCfg(4'b1011, 2, 3, 2, 0, 4, 0, 3, 4);
      for (int d = 0; d < 16; d++)
        for (int t = 0; t < 16; t++)
          runPass(4'(d), 4'(t), "sweep");
    end

    // R8: nothing eligible leaves heads alone; verified by the next grant's index
    setCfg(4'b1111, 0, 0, 0, 0, 2, 3, 2, 3);
    runPass(4'b0000, 4'b1111, "R8 blocked timers");
    setCfg(4'b1111, 0, 0, 0, 0, 0, 0, 0, 0);
    runPass(4'b0000, 4'b1111, "R8 head kept");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule